// File: doc/BRIEF.md
# SPI Master Word Engine with Register Interface

This block is a single-slave SPI master for a simple 32-bit register bus. Software sets the word length (8 or 16 bits) and an even clock divide ratio in a configuration register, raises chip select through a control bit, and then writes a word to the transmit offset. That write starts one full-duplex exchange. The transmit word goes out on MOSI while the slave's reply comes in on MISO. When the exchange ends, a completion flag is set, and the received word can be read from the receive offset.

Only SPI mode 0 is supported. SCK idles low, the master samples MISO on each rising edge, and it moves MOSI on each falling edge. Bits go out most significant first, and the first bit appears on MOSI as soon as the exchange begins. A write to the transmit offset during an exchange is ignored. Divide ratio and word length are captured when an exchange starts, so changing them during a word has no effect on that word. Register reads are combinational.

Top module: `spim_ctrl_top`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck and spi_mosi are 0, offset 0x10 reads 0, offset 0x0C reads 0, and offset 0x04 reads 0x12.
- R2: Bit 0 of offset 0x00 (read back at bit 0) drives chip select: writing 1 drives spi_cs_n low and writing 0 drives it high, from the cycle after the write.
- R3: Offset 0x04 keeps only bits [5:0]. Its reserved bits read as zero. Offsets 0x08, 0x14, 0x18 and 0x1C read as zero.
- R4: A write to offset 0x08 while the engine is idle starts one exchange of bus bits [15:0] (16-bit mode) or [7:0] (8-bit mode), sent MSB first. The first bit is on spi_mosi in the cycle after the write, and spi_mosi is 0 while idle.
- R5: Offset 0x04 bit 5 selects the word length (1 = 16 bits, 0 = 8 bits). The half period H is bits [3:0] of offset 0x04, and values below 2 are treated as 2. spi_sck idles low and gives exactly one rising edge per bit. The exchange completes 2*H*bits clock cycles after the starting write.
- R6: MISO is sampled on each SCK rising edge, MSB first. Offset 0x0C returns the last completed received word, zero-extended to 32 bits, and holds it until the next exchange completes.
- R7: Bit 0 of offset 0x10 becomes 1 in the cycle after an exchange completes. A write with bit 0 equal to 0 clears it. A write with bit 0 equal to 1 leaves it unchanged.
- R8: When an exchange completes in the same cycle as a clearing write to offset 0x10, the flag ends up set.
- R9: A write to offset 0x08 while an exchange is in progress is ignored. The exchange in progress keeps its data and its timing, and no second exchange follows it.
- R10: A write to offset 0x04 during an exchange does not change the length, timing or word size of that exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 5 | Byte offset for read and write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| spi_sck_o | output | 1 | Serial clock, idles low |
| spi_mosi_o | output | 1 | Serial data out |
| spi_miso_i | input | 1 | Serial data in |
| spi_cs_n_o | output | 1 | Chip select, active low |

## Verification
Two events can fall in the same clock edge: the end of an exchange setting the completion flag, and a software write of zero to offset 0x10 clearing it. The bench knows from the configuration exactly which edge closes each exchange (2*H*bits cycles after the start), so it places the clearing write on that edge. The flag must read 0 just before that edge and 1 just after it. The bench also writes to the transmit and configuration offsets halfway through an exchange, and judges those writes by the data captured from MOSI, the number of SCK edges and the completion time.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int BUS_W     = 32;
  localparam int ADDR_W    = 5;
  localparam int WORD_W    = 16;
  localparam int SHORT_W   = 8;
  localparam int HALF_W    = 4;
  localparam int CFG_W     = 6;
  localparam int BITCNT_W  = $clog2(WORD_W);
  localparam int HALF_MIN  = 2;
  localparam logic [CFG_W-1:0] CFG_RESET = 6'h12;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_TX    = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_RX    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CAUSE = 5'h10;

  localparam int CFG_WIDE_BIT = 5;
endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv
  import spim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              tick_o
);
  logic [HALF_W-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == half_i - HALF_W'(1));

  always_comb begin
    cnt_d = cnt_q + HALF_W'(1);
    if (!run_i || tick_o) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wide_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic [WORD_W-1:0] tx_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              finish_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_o
);
  logic              busy_q, busy_d;
  logic              sck_q, sck_d;
  logic              wide_q, wide_d;
  logic [HALF_W-1:0] half_q, half_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] rx_q, rx_d;
  logic [BITCNT_W-1:0] bit_q, bit_d;
  logic              tick, last;

  spim_clkdiv u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q),
    .half_i (half_q),
    .tick_o (tick)
  );

  assign last     = (bit_q == (wide_q ? BITCNT_W'(WORD_W-1) : BITCNT_W'(SHORT_W-1)));
  assign finish_o = busy_q && tick && sck_q && last;
  assign busy_o   = busy_q;
  assign sck_o    = sck_q;
  assign mosi_o   = busy_q && sh_q[WORD_W-1];
  assign rx_o     = wide_q ? rx_q : {{(WORD_W-SHORT_W){1'b0}}, rx_q[SHORT_W-1:0]};

  always_comb begin
    busy_d = busy_q;
    sck_d  = sck_q;
    wide_d = wide_q;
    half_d = half_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    bit_d  = bit_q;
    if (start_i && !busy_q) begin
      busy_d = 1'b1;
      sck_d  = 1'b0;
      wide_d = wide_i;
      half_d = half_i;
      sh_d   = wide_i ? tx_i : {tx_i[SHORT_W-1:0], {(WORD_W-SHORT_W){1'b0}}};
      rx_d   = '0;
      bit_d  = '0;
    end else if (busy_q && tick) begin
      if (!sck_q) begin
        sck_d = 1'b1;
        rx_d  = {rx_q[WORD_W-2:0], miso_i};
      end else begin
        sck_d = 1'b0;
        if (last) begin
          busy_d = 1'b0;
        end else begin
          sh_d  = {sh_q[WORD_W-2:0], 1'b0};
          bit_d = bit_q + BITCNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      wide_q <= 1'b0;
      half_q <= HALF_W'(HALF_MIN);
      sh_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      wide_q <= wide_d;
      half_q <= half_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      bit_q  <= bit_d;
    end
  end
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              busy_i,
  input  logic              finish_i,
  input  logic [WORD_W-1:0] rx_i,
  output logic              start_o,
  output logic              wide_o,
  output logic [HALF_W-1:0] half_o,
  output logic              cs_o,
  output logic              done_o
);
  logic              cs_q, cs_d;
  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic              done_q, done_d;
  logic [WORD_W-1:0] rxd_q, rxd_d;
  logic              wr_ctrl, wr_cfg, wr_cause;

  assign wr_ctrl  = wr_i && (addr_i == OFS_CTRL);
  assign wr_cfg   = wr_i && (addr_i == OFS_CFG);
  assign wr_cause = wr_i && (addr_i == OFS_CAUSE);
  assign start_o  = wr_i && (addr_i == OFS_TX) && !busy_i;
  assign wide_o   = cfg_q[CFG_WIDE_BIT];
  assign half_o   = (cfg_q[HALF_W-1:0] < HALF_W'(HALF_MIN)) ? HALF_W'(HALF_MIN)
                                                            : cfg_q[HALF_W-1:0];
  assign cs_o     = cs_q;
  assign done_o   = done_q;

  always_comb begin
    cs_d   = wr_ctrl ? wdata_i[0] : cs_q;
    cfg_d  = wr_cfg  ? wdata_i[CFG_W-1:0] : cfg_q;
    rxd_d  = finish_i ? rx_i : rxd_q;
    done_d = done_q;
    if (finish_i)                     done_d = 1'b1;
    else if (wr_cause && !wdata_i[0]) done_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b0;
      cfg_q  <= CFG_RESET;
      done_q <= 1'b0;
      rxd_q  <= '0;
    end else begin
      cs_q   <= cs_d;
      cfg_q  <= cfg_d;
      done_q <= done_d;
      rxd_q  <= rxd_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL:  rdata_o[0] = cs_q;
      OFS_CFG:   rdata_o[CFG_W-1:0] = cfg_q;
      OFS_RX:    rdata_o[WORD_W-1:0] = rxd_q;
      OFS_CAUSE: rdata_o[0] = done_q;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spim_ctrl_top.sv
module spim_ctrl_top
  import spim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              spi_sck_o,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i,
  output logic              spi_cs_n_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              eng_start, eng_busy, eng_finish, eng_wide;
  logic [HALF_W-1:0] eng_half;
  logic [WORD_W-1:0] eng_rx;
  logic              cs_act, done_flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  spim_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .busy_i   (eng_busy),
    .finish_i (eng_finish),
    .rx_i     (eng_rx),
    .start_o  (eng_start),
    .wide_o   (eng_wide),
    .half_o   (eng_half),
    .cs_o     (cs_act),
    .done_o   (done_flag)
  );

  spim_shifter u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .start_i  (eng_start),
    .wide_i   (eng_wide),
    .half_i   (eng_half),
    .tx_i     (bus_wdata_i[WORD_W-1:0]),
    .miso_i   (spi_miso_i),
    .busy_o   (eng_busy),
    .finish_o (eng_finish),
    .sck_o    (spi_sck_o),
    .mosi_o   (spi_mosi_o),
    .rx_o     (eng_rx)
  );

  assign spi_cs_n_o = !cs_act;
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk
  import spim_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [BUS_W-1:0]  bus_wdata_i,
  input logic              eng_busy,
  input logic              eng_finish,
  input logic              done_flag,
  input logic              spi_sck_o,
  input logic              spi_mosi_o,
  input logic              spi_cs_n_o
);
  AST_CS_FOLLOWS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == OFS_CTRL) |=> (spi_cs_n_o == !$past(bus_wdata_i[0]))); // R2
  AST_MOSI_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_busy |-> !spi_mosi_o); // R4
  AST_START_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eng_busy) |-> $past(bus_wr_i && bus_addr_i == OFS_TX)); // R4
  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_busy |-> !spi_sck_o); // R5
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == OFS_CAUSE && !bus_wdata_i[0] && !eng_finish) |=> !done_flag); // R7
  AST_FINISH_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_finish |=> done_flag); // R8
endmodule

bind spim_ctrl_top spim_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_sync_n),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .eng_busy    (eng_busy),
  .eng_finish  (eng_finish),
  .done_flag   (done_flag),
  .spi_sck_o   (spi_sck_o),
  .spi_mosi_o  (spi_mosi_o),
  .spi_cs_n_o  (spi_cs_n_o)
);

// File: tb/spim_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module spim_ctrl_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [4:0]  bus_addr_i = 5'h0;
  logic [31:0] bus_wdata_i = 32'h0;
  logic [31:0] bus_rdata_o;
  logic        spi_sck_o, spi_mosi_o, spi_cs_n_o;
  logic        spi_miso_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [15:0] cap_q = 16'h0;
  logic [15:0] sl_sh = 16'h0;
  int          rises = 0;

  spim_ctrl_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .spi_sck_o(spi_sck_o),
    .spi_mosi_o(spi_mosi_o), .spi_miso_i(spi_miso_i), .spi_cs_n_o(spi_cs_n_o)
  );

  always #2 clk_i = ~clk_i;

  always @(posedge spi_sck_o) begin
    cap_q = {cap_q[14:0], spi_mosi_o};
    rises = rises + 1;
  end
  always @(negedge spi_sck_o) begin
    sl_sh = {sl_sh[14:0], 1'b0};
    spi_miso_i = sl_sh[15];
  end

  always @(posedge clk_i) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL WATCHDOG: run hung act=%0d exp=<150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #1;
    d = bus_rdata_o;
  endtask

  function automatic int exp_half(input logic [5:0] cfg);
    return (cfg[3:0] < 4'd2) ? 2 : int'(cfg[3:0]);
  endfunction

  function automatic logic [15:0] width_mask(input logic [15:0] v, input logic wide);
    return wide ? v : {8'h00, v[7:0]};
  endfunction

  // mode 0: plain, 1: clear collides with completion (R8),
  // 2: transmit write while busy (R9), 3: config write while busy (R10)
  task automatic xfer(input logic [15:0] tx, input logic [15:0] sl,
                      input logic [5:0] cfg, input int mode);
    logic        wide;
    int          nb, t;
    logic [31:0] r;
    wide = cfg[5];
    nb   = wide ? 16 : 8;
    t    = 2 * exp_half(cfg) * nb;
    wr(5'h04, {26'h0, cfg});
    wr(5'h10, 32'h0);
    sl_sh = wide ? sl : {sl[7:0], 8'h00};
    spi_miso_i = sl_sh[15];
    rises = 0;
    cap_q = 16'h0;
    wr(5'h08, {16'hA5A5, tx});
    check("R4 first bit on mosi", {31'h0, spi_mosi_o}, {31'h0, wide ? tx[15] : tx[7]});
    for (int i = 1; i < t; i++) begin
      if (mode == 2 && i == t / 2) begin
        bus_wr_i = 1'b1; bus_addr_i = 5'h08; bus_wdata_i = {16'h0, ~tx};
      end
      if (mode == 3 && i == t / 2) begin
        bus_wr_i = 1'b1; bus_addr_i = 5'h04; bus_wdata_i = {26'h0, ~cfg[5], 5'h1F};
      end
      @(negedge clk_i);
      bus_wr_i = 1'b0;
    end
    rd(5'h10, r);
    check("R5 not done before 2*H*bits", r, 32'h0);
    if (mode == 1) begin
      bus_wr_i = 1'b1; bus_addr_i = 5'h10; bus_wdata_i = 32'h0;
    end
    @(negedge clk_i);
    bus_wr_i = 1'b0;
    rd(5'h10, r);
    check(mode == 1 ? "R8 completion beats clear" : "R7 flag set at completion", r, 32'h1);
    check("R5 one sck rise per bit", rises, nb);
    check("R5 sck idle low after word", {31'h0, spi_sck_o}, 32'h0);
    check(mode == 2 ? "R9 tx kept under busy write" : "R4 msb-first mosi data",
          {16'h0, width_mask(cap_q, wide)}, {16'h0, width_mask(tx, wide)});
    rd(5'h0C, r);
    check(mode == 3 ? "R10 config held mid-word" : "R6 received word",
          r, {16'h0, width_mask(sl, wide)});
    if (mode == 2) begin
      repeat (2 * t) @(negedge clk_i);
      check("R9 no second exchange", rises, nb);
    end
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    check("R1 cs_n after reset", {31'h0, spi_cs_n_o}, 32'h1);
    check("R1 sck after reset", {31'h0, spi_sck_o}, 32'h0);
    check("R1 mosi after reset", {31'h0, spi_mosi_o}, 32'h0);
    rd(5'h10, r); check("R1 flag after reset", r, 32'h0);
    rd(5'h0C, r); check("R1 rx after reset", r, 32'h0);
    rd(5'h04, r); check("R1 cfg after reset", r, 32'h12);

    wr(5'h00, 32'hFFFF_FFFF);
    check("R2 cs asserted", {31'h0, spi_cs_n_o}, 32'h0);
    rd(5'h00, r); check("R2 ctrl readback", r, 32'h1);
    wr(5'h00, 32'h0000_0002);
    check("R2 cs released", {31'h0, spi_cs_n_o}, 32'h1);
    wr(5'h00, 32'h1);

    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, r); check("R3 cfg reserved bits zero", r, 32'h3F);
    rd(5'h08, r); check("R3 tx offset reads zero", r, 32'h0);
    rd(5'h14, r); check("R3 unused 0x14", r, 32'h0);
    rd(5'h18, r); check("R3 unused 0x18", r, 32'h0);
    rd(5'h1C, r); check("R3 unused 0x1C", r, 32'h0);

    xfer(16'h00A5, 16'h003C, 6'h12, 0);
    xfer(16'hBEEF, 16'h1234, 6'h32, 0);
    xfer(16'h0081, 16'h00FF, 6'h1F, 0);
    xfer(16'hFFFF, 16'h8001, 6'h3F, 0);
    xfer(16'h0000, 16'hC3C3, 6'h20, 0);

    wr(5'h10, 32'h1);
    rd(5'h10, r); check("R7 write of one keeps flag", r, 32'h1);
    wr(5'h10, 32'h0);
    rd(5'h10, r); check("R7 write of zero clears", r, 32'h0);
    rd(5'h0C, r); check("R6 rx held after clear", r, 32'h0000C3C3);

    xfer(16'h5A5A, 16'hA5A5, 6'h33, 1);
    xfer(16'h00C7, 16'h0019, 6'h14, 1);
    xfer(16'h1357, 16'h9BDF, 6'h34, 2);
    xfer(16'h0066, 16'h0099, 6'h13, 2);
    xfer(16'h2468, 16'h8642, 6'h33, 3);
    xfer(16'h004D, 16'h00B2, 6'h03, 3);

    for (int k = 0; k < 24; k++) begin
      xfer(16'($urandom), 16'($urandom), 6'($urandom), int'($urandom % 4));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule